// File: doc/BRIEF.md
# Multichannel sample frame packer

This block takes a snapshot of 17 channel samples, each 24 bits wide, on a single sample strobe. It then sends that snapshot out as a run of 64-bit words through a valid/ready write port that feeds a DMA-style FIFO. Fast channels present fresh values at the strobe. Slow channels present whatever their holding registers contain at that moment. Every frame is therefore a synchronous set of values, and a slow channel never delays a frame.

Two output layouts are available, and a select input chooses between them at the start of each frame.

- **Dense layout:** the 408 frame bits are packed back to back into seven words, so a sample may straddle two words.
- **Padded layout:** each sample is placed in its own 32-bit slot, with two slots per word, for nine words in total.

Words carry no header. A receiver finds frame boundaries by counting words, because the word count per frame is fixed for each layout.

If a strobe arrives while a frame is still draining, that new snapshot is dropped and a sticky overflow flag is raised. The flag stays set until software-facing logic pulses the clear input.

Top module: `frame_packer`

## Requirements
- R1: While `rst_n` is low and after reset, `word_valid_o` and `overflow_o` are low.
- R2: A strobe accepted while idle captures all 17 channels in that same cycle. Changes on `ch_data_i` after that cycle do not alter the frame being emitted.
- R3: With `dense_sel_i`=1 at frame start, the frame is 7 words. Channel n occupies frame bits [24n+23:24n], where frame bit b sits in word b/64 at bit b%64. Bits 63:24 of word 6 are zero.
- R4: With `dense_sel_i`=0 at frame start, the frame is 9 words. Channel n sits in bits [32(n%2)+23:32(n%2)] of word n/2, bits [32(n%2)+31:32(n%2)+24] of that word are zero, and bits 63:32 of word 8 are zero.
- R5: A word transfers only in a cycle where `word_valid_o` and `word_ready_i` are both high. While ready is low, `word_valid_o` stays high and `word_o` holds its value.
- R6: The first word appears the cycle after the accepted strobe. Once the last word of the frame has transferred, `word_valid_o` falls unless R10 applies.
- R7: A strobe that arrives while a frame is in flight and is not coincident with its final transfer is discarded. It sets `overflow_o` the next cycle, and the frame in flight continues unchanged.
- R8: `overflow_o` stays high until a cycle with `ovf_clr_i` high clears it. If clear and a new overflow fall in the same cycle, the overflow wins.
- R9: `dense_sel_i` is sampled only when a frame is captured. Changing it mid-frame does not affect the word count or layout of the frame in flight.
- R10: A strobe in the same cycle as the final word's transfer starts a new frame without overflow. Its first word is valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Sample strobe of the fastest acquisition loop |
| dense_sel_i | input | 1 | Layout select: 1 dense, 0 padded |
| ch_data_i | input | 408 | Channel samples, channel n at bits [24n+23:24n] |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| word_ready_i | input | 1 | FIFO write port can accept a word |
| word_o | output | 64 | Output word |
| word_valid_o | output | 1 | `word_o` holds a valid word |
| overflow_o | output | 1 | Sticky flag: a strobe was dropped |

## Verification
Two functions can land in the same cycle: the handshake of a frame's last word and the arrival of a new strobe. They fall together only when the strobe is raised exactly in the cycle where ready completes the final transfer. The bench provokes this by asserting strobe and ready together on the final word of a padded frame, while also switching the layout and the channel data. It judges the result by checking three things: the first dense word of the new frame is valid on the very next cycle, the new frame comes out complete, and the overflow flag stays low. A strobe one word earlier is judged separately and must set the flag and leave the old frame intact.

// File: rtl/fp_pkg.sv
// Package for the frame packer.
// Holds the layout encoding and a ceiling-division helper used to size
// the word counts. Assumes only integer arithmetic on parameters.
package fp_pkg;

    typedef enum logic {
        LAYOUT_PADDED = 1'b0,
        LAYOUT_DENSE  = 1'b1
    } layout_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/fp_capture.sv
// Frame capture register.
// Latches the full set of channel samples in the cycle that load is high
// and holds them otherwise. Assumes load is only raised when no frame is
// being emitted, which the emit controller guarantees.
module fp_capture #(
    parameter int FRAME_BITS = 408
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] data_in,
    output logic [FRAME_BITS-1:0] frame_q
);

    // Snapshot register: captures all channels together on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_q <= '0;
        else if (load)
            frame_q <= data_in;
    end

    AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(frame_q)); // R2

endmodule

// File: rtl/fp_word_mux.sv
// Word selector.
// Builds both the dense and the padded views of the latched frame and
// returns the word at the given index for the chosen layout. Purely
// combinational. Assumes idx stays below the word count of the layout.
module fp_word_mux
    import fp_pkg::*;
#(
    parameter int NUM_CH      = 17,
    parameter int SAMPLE_W    = 24,
    parameter int WORD_W      = 64,
    parameter int SLOT_W      = 32,
    parameter int DENSE_WORDS = 7,
    parameter int PAD_WORDS   = 9,
    parameter int IDX_W       = 4
) (
    input  logic [NUM_CH*SAMPLE_W-1:0] frame,
    input  layout_e                    layout,
    input  logic [IDX_W-1:0]           idx,
    output logic [WORD_W-1:0]          word
);

    localparam int FRAME_BITS = NUM_CH * SAMPLE_W;
    localparam int DENSE_BITS = DENSE_WORDS * WORD_W;
    localparam int PAD_BITS   = PAD_WORDS * WORD_W;
    localparam int PAD_SLOTS  = PAD_BITS / SLOT_W;
    localparam int FILL_W     = SLOT_W - SAMPLE_W;

    logic [DENSE_BITS-1:0] dense_vec;
    logic [PAD_BITS-1:0]   pad_vec;

    // Dense view: samples back to back, tail zero-filled.
    assign dense_vec[FRAME_BITS-1:0] = frame;
    generate
        if (DENSE_BITS > FRAME_BITS) begin : g_dense_tail
            assign dense_vec[DENSE_BITS-1:FRAME_BITS] = '0;
        end
    endgenerate

    // Padded view: one sample per slot, zero filler above, unused slots zero.
    generate
        for (genvar s = 0; s < PAD_SLOTS; s++) begin : g_slot
            if (s < NUM_CH) begin : g_used
                assign pad_vec[s*SLOT_W +: SLOT_W] =
                    {{FILL_W{1'b0}}, frame[s*SAMPLE_W +: SAMPLE_W]};
            end else begin : g_empty
                assign pad_vec[s*SLOT_W +: SLOT_W] = '0;
            end
        end
    endgenerate

    // Word select: index into the view of the active layout.
    always_comb begin
        word = '0;
        if (layout == LAYOUT_DENSE) begin
            if (int'(idx) < DENSE_WORDS)
                word = dense_vec[int'(idx)*WORD_W +: WORD_W];
        end else begin
            if (int'(idx) < PAD_WORDS)
                word = pad_vec[int'(idx)*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/fp_emit_ctrl.sv
// Emit controller.
// Decides when a strobe may capture a frame, steps the word index on each
// handshake, latches the layout at frame start, and keeps the sticky
// overflow flag. A strobe that coincides with the final transfer is
// accepted. If clear and overflow fall in the same cycle, the set wins.
module fp_emit_ctrl
    import fp_pkg::*;
#(
    parameter int DENSE_WORDS = 7,
    parameter int PAD_WORDS   = 9,
    parameter int IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             dense_sel,
    input  logic             ovf_clr,
    input  logic             ready,
    output logic             load,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output layout_e          layout_q,
    output logic             overflow
);

    localparam logic [IDX_W-1:0] DENSE_LAST = IDX_W'(DENSE_WORDS - 1);
    localparam logic [IDX_W-1:0] PAD_LAST   = IDX_W'(PAD_WORDS - 1);

    logic [IDX_W-1:0] last_idx;
    logic             xfer;
    logic             done;
    logic             free;
    logic             ovf_evt;

    // Handshake and acceptance decode.
    always_comb begin
        last_idx = (layout_q == LAYOUT_DENSE) ? DENSE_LAST : PAD_LAST;
        xfer     = valid && ready;
        done     = xfer && (idx == last_idx);
        free     = !valid || done;
        load     = strobe && free;
        ovf_evt  = strobe && !free;
    end

    // Frame sequencing: start, advance, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            idx      <= '0;
            layout_q <= LAYOUT_PADDED;
        end else if (load) begin
            valid    <= 1'b1;
            idx      <= '0;
            layout_q <= dense_sel ? LAYOUT_DENSE : LAYOUT_PADDED;
        end else if (done) begin
            valid    <= 1'b0;
            idx      <= '0;
        end else if (xfer) begin
            idx      <= idx + 1'b1;
        end
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (ovf_evt)
            overflow <= 1'b1;
        else if (ovf_clr)
            overflow <= 1'b0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !valid && !overflow); // R1
    AST_HOLD_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(idx) && $stable(layout_q)); // R5
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> idx <= last_idx); // R6
    AST_OVF_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && valid && !(ready && idx == last_idx) |=> overflow); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !ovf_clr |=> overflow); // R8
    AST_CHAINED_START: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && valid && ready && idx == last_idx |=> valid && idx == '0); // R10

endmodule

// File: rtl/frame_packer.sv
// Multichannel sample frame packer (top).
// Captures all channel samples on a strobe and streams them out as
// fixed-count 64-bit words in a dense or padded layout over valid/ready.
// Assumes channel n is presented at ch_data_i[SAMPLE_W*n +: SAMPLE_W].
module frame_packer
    import fp_pkg::*;
#(
    parameter int NUM_CH   = 17,
    parameter int SAMPLE_W = 24,
    parameter int WORD_W   = 64,
    parameter int SLOT_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe_i,
    input  logic                       dense_sel_i,
    input  logic [NUM_CH*SAMPLE_W-1:0] ch_data_i,
    input  logic                       ovf_clr_i,
    input  logic                       word_ready_i,
    output logic [WORD_W-1:0]          word_o,
    output logic                       word_valid_o,
    output logic                       overflow_o
);

    localparam int FRAME_BITS     = NUM_CH * SAMPLE_W;
    localparam int DENSE_WORDS    = ceil_div(FRAME_BITS, WORD_W);
    localparam int SLOTS_PER_WORD = WORD_W / SLOT_W;
    localparam int PAD_WORDS      = ceil_div(NUM_CH, SLOTS_PER_WORD);
    localparam int MAX_WORDS      = (DENSE_WORDS > PAD_WORDS) ? DENSE_WORDS : PAD_WORDS;
    localparam int IDX_W          = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

    logic                  load;
    logic [IDX_W-1:0]      idx;
    layout_e               layout_q;
    logic [FRAME_BITS-1:0] frame_q;

    fp_emit_ctrl #(
        .DENSE_WORDS(DENSE_WORDS),
        .PAD_WORDS  (PAD_WORDS),
        .IDX_W      (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe_i),
        .dense_sel(dense_sel_i),
        .ovf_clr  (ovf_clr_i),
        .ready    (word_ready_i),
        .load     (load),
        .valid    (word_valid_o),
        .idx      (idx),
        .layout_q (layout_q),
        .overflow (overflow_o)
    );

    fp_capture #(
        .FRAME_BITS(FRAME_BITS)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .data_in(ch_data_i),
        .frame_q(frame_q)
    );

    fp_word_mux #(
        .NUM_CH     (NUM_CH),
        .SAMPLE_W   (SAMPLE_W),
        .WORD_W     (WORD_W),
        .SLOT_W     (SLOT_W),
        .DENSE_WORDS(DENSE_WORDS),
        .PAD_WORDS  (PAD_WORDS),
        .IDX_W      (IDX_W)
    ) u_mux (
        .frame (frame_q),
        .layout(layout_q),
        .idx   (idx),
        .word  (word_o)
    );

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_o)); // R5

endmodule

// File: tb/sim_frame_packer.sv
// Directed bench for frame_packer: one task per scenario.
module sim_frame_packer;

    localparam int NCH = 17;
    localparam int SW  = 24;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              strobe_i;
    logic              dense_sel_i;
    logic [NCH*SW-1:0] ch_data_i;
    logic              ovf_clr_i;
    logic              word_ready_i;
    logic [63:0]       word_o;
    logic              word_valid_o;
    logic              overflow_o;

    int checks = 0;
    int fails  = 0;
    logic [SW-1:0] exp_ch [NCH];

    frame_packer u0 (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .dense_sel_i(dense_sel_i),
        .ch_data_i(ch_data_i), .ovf_clr_i(ovf_clr_i), .word_ready_i(word_ready_i),
        .word_o(word_o), .word_valid_o(word_valid_o), .overflow_o(overflow_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Expected word built from the layout rules (R3, R4).
    function automatic logic [63:0] exp_word(input bit dense, input int k);
        logic [1023:0] v;
        v = '0;
        for (int n = 0; n < NCH; n++) begin
            if (dense) v[n*24 +: 24] = exp_ch[n];
            else       v[n*32 +: 32] = {8'h00, exp_ch[n]};
        end
        return v[k*64 +: 64];
    endfunction

    function automatic int nwords(input bit dense);
        return dense ? 7 : 9;
    endfunction

    task automatic set_pattern(input int seed);
        for (int n = 0; n < NCH; n++)
            exp_ch[n] = 24'((seed * 32'h9E3779B1) ^ (n * 32'h00A5_1C37) ^ (n << 20));
    endtask

    task automatic drive_channels();
        for (int n = 0; n < NCH; n++) ch_data_i[n*SW +: SW] = exp_ch[n];
    endtask

    // Called at a negedge; strobes one frame.
    task automatic start_frame(input bit dense);
        drive_channels();
        dense_sel_i = dense;
        strobe_i    = 1'b1;
        @(negedge clk);
        strobe_i    = 1'b0;
        ch_data_i   = {NCH{24'h5A5A5A}};   // R2: later input changes ignored
        dense_sel_i = ~dense;                // R9: select flips mid-frame
    endtask

    // Receive words [0, count) starting at a negedge where word 0 is shown.
    task automatic recv(input bit dense, input bit stall, input int count, input string req);
        for (int k = 0; k < count; k++) begin
            if (stall) begin
                word_ready_i = 1'b0;
                @(negedge clk);
                check(word_valid_o && word_o == exp_word(dense, k), "R5 hold", word_o, exp_word(dense, k));
            end
            check(word_valid_o && word_o == exp_word(dense, k), req, word_o, exp_word(dense, k));
            word_ready_i = 1'b1;
            @(negedge clk);
        end
        word_ready_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; strobe_i = 0; dense_sel_i = 0; ch_data_i = '0;
        ovf_clr_i = 0; word_ready_i = 0;
        repeat (3) @(negedge clk);
        check(!word_valid_o && !overflow_o, "R1 in reset", {62'd0, word_valid_o, overflow_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!word_valid_o && !overflow_o, "R1 after reset", {62'd0, word_valid_o, overflow_o}, 64'd0);
    endtask

    task automatic t_frame(input bit dense, input bit stall, input int seed);
        set_pattern(seed);
        start_frame(dense);
        recv(dense, stall, nwords(dense), dense ? "R3 dense word" : "R4 padded word");
        check(!word_valid_o, "R6 end after count / R9", {63'd0, word_valid_o}, 64'd0);
    endtask

    task automatic t_all_ones();
        for (int n = 0; n < NCH; n++) exp_ch[n] = 24'hFFFFFF;
        start_frame(1'b1);
        recv(1'b1, 1'b0, 6, "R3 straddle");
        check(word_o[63:24] == 40'd0, "R3 top zero", word_o, {40'd0, 24'hFFFFFF});
        recv(1'b1, 1'b0, 0, "R3");
        word_ready_i = 1'b1; @(negedge clk); word_ready_i = 1'b0;
        check(!word_valid_o, "R6", {63'd0, word_valid_o}, 64'd0);
        set_pattern(77);
        start_frame(1'b0);
        recv(1'b0, 1'b0, 8, "R4 padded");
        check(word_o == {32'd0, 8'd0, exp_ch[16]}, "R4 last slot", word_o, {32'd0, 8'd0, exp_ch[16]});
        word_ready_i = 1'b1; @(negedge clk); word_ready_i = 1'b0;
    endtask

    task automatic t_overflow();
        set_pattern(5);
        start_frame(1'b1);
        recv(1'b1, 1'b0, 2, "R7 before");
        ch_data_i = {NCH{24'h123456}};
        strobe_i = 1'b1;
        @(negedge clk);
        strobe_i = 1'b0;
        check(overflow_o, "R7 flag set", {63'd0, overflow_o}, 64'd1);
        // Index 2 is still shown because ready was low in that cycle.
        for (int k = 2; k < 7; k++) begin
            check(word_valid_o && word_o == exp_word(1'b1, k), "R7 frame intact", word_o, exp_word(1'b1, k));
            word_ready_i = 1'b1; @(negedge clk);
        end
        word_ready_i = 1'b0;
        check(!word_valid_o, "R7 no new frame", {63'd0, word_valid_o}, 64'd0);
        repeat (3) @(negedge clk);
        check(overflow_o, "R8 sticky", {63'd0, overflow_o}, 64'd1);
        ovf_clr_i = 1'b1; @(negedge clk); ovf_clr_i = 1'b0;
        check(!overflow_o, "R8 cleared", {63'd0, overflow_o}, 64'd0);
    endtask

    task automatic t_chain();
        set_pattern(9);
        start_frame(1'b0);
        recv(1'b0, 1'b1, 8, "R10 first frame");
        check(word_o == exp_word(1'b0, 8), "R10 last word", word_o, exp_word(1'b0, 8));
        set_pattern(42);
        drive_channels();
        dense_sel_i  = 1'b1;
        strobe_i     = 1'b1;
        word_ready_i = 1'b1;
        @(negedge clk);
        strobe_i     = 1'b0;
        word_ready_i = 1'b0;
        check(word_valid_o && !overflow_o, "R10 chained start", {62'd0, word_valid_o, overflow_o}, 64'd2);
        recv(1'b1, 1'b0, 7, "R10 new frame");
        check(!word_valid_o && !overflow_o, "R10 end", {62'd0, word_valid_o, overflow_o}, 64'd0);
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_frame(1'b1, 1'b0, 1);   // R3, R2
        t_frame(1'b0, 1'b1, 2);   // R4, R5, R9
        t_frame(1'b1, 1'b1, 3);   // R3, R5, R9
        t_all_ones();             // R3, R4
        t_overflow();             // R7, R8
        t_chain();                // R10
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule